// File: doc/BRIEF.md
# Four-Phase Accumulator Processor Core

This block is a small, non-pipelined processor built around one data register, the accumulator. It keeps a program counter and an instruction register, and it uses a single memory for both code and data. A phase sequencer takes every instruction through the same four steps in a fixed order. Fetch places the program counter on the memory address. Decode captures the returned word into the instruction register. Operand preparation reads the memory word at the address carried by the instruction. Execute applies the selected operation.

The memory port is synchronous. An address presented in one cycle returns its word in the next cycle, and a write happens at the clock edge in which the write enable is high. Each instruction therefore takes exactly four cycles. A halt instruction freezes the sequencer and raises the halt output, which stays high until the next reset. The core is meant to drive a plain single-port RAM that holds a preloaded program and its data.

Top module: `acc_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the memory address is 0, the write enable is low and the halt output is low.
- R2: Every instruction occupies exactly four consecutive cycles, in this order: fetch, decode, operand preparation, execute. The next fetch follows execute directly.
- R3: An instruction is 16 bits wide. Bits [15:12] hold the opcode and bits [11:0] hold an absolute word address. In fetch, the program counter drives the memory address. In decode, the program counter advances by one.
- R4: In operand preparation and in execute, the memory address equals bits [11:0] of the current instruction.
- R5: ADD (opcode 1) adds the memory word at the operand address to the accumulator, wrapping modulo 2^16.
- R6: MOVL (opcode 2) loads the memory word at the operand address into the accumulator.
- R7: MOVS (opcode 3) writes the accumulator to the operand address during its execute cycle. The write enable is never high at any other time.
- R8: SHR (opcode 4) shifts the accumulator right by one bit and fills bit 15 with zero.
- R9: JMP (opcode 5) loads the operand address into the program counter, so the next fetch comes from that address.
- R10: JZ (opcode 6) jumps to the operand address when the accumulator is zero. Otherwise execution continues with the next word.
- R11: HLT (opcode 0) raises the halt output in the cycle after its execute phase. From then until reset, the halt output stays high, the memory address holds steady, no write occurs and no later instruction runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address to the unified memory |
| mem_wdata | output | 16 | Write data, always the accumulator |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_we | output | 1 | Write enable, high only for a store |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Small programs load operands into the accumulator and then store results back to memory, so every result is visible at the memory port.

The ADD cases use one operand pair that carries past bit 15 and one that does not, which separates wrapping arithmetic from a saturating or widened sum. The SHR cases use values with the top bit set and with the bottom bit set, which distinguishes a logical shift from an arithmetic shift or a rotate. The jump cases preset memory locations and place stores on both the taken and the skipped paths, so a wrong branch decision changes which preset survives. A cycle-by-cycle trace of the address bus covers the phase order and the halt boundary.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_HLT  = 4'd0,
        OP_ADD  = 4'd1,
        OP_MOVL = 4'd2,
        OP_MOVS = 4'd3,
        OP_SHR  = 4'd4,
        OP_JMP  = 4'd5,
        OP_JZ   = 4'd6
    } opcode_t;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_PREP   = 2'd2,
        PH_EXEC   = 2'd3
    } phase_t;

endpackage

// File: rtl/acc_phase_gen.sv
module acc_phase_gen
    import acc_core_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt_req,
    output phase_t phase,
    output logic   halted
);

    typedef struct packed {
        phase_t ph;
        logic   stop;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.stop) begin
            unique case (seq_q.ph)
                PH_FETCH:  seq_d.ph = PH_DECODE;
                PH_DECODE: seq_d.ph = PH_PREP;
                PH_PREP:   seq_d.ph = PH_EXEC;
                PH_EXEC: begin
                    if (halt_req) begin
                        seq_d.stop = 1'b1;
                    end else begin
                        seq_d.ph = PH_FETCH;
                    end
                end
                default:   seq_d.ph = PH_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_FETCH, stop: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase  = seq_q.ph;
    assign halted = seq_q.stop;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_t           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              writes_acc,
    output logic              acc_zero
);

    always_comb begin
        result     = acc;
        writes_acc = 1'b0;
        unique case (op)
            OP_ADD: begin
                result     = acc + operand;
                writes_acc = 1'b1;
            end
            OP_MOVL: begin
                result     = operand;
                writes_acc = 1'b1;
            end
            OP_SHR: begin
                result     = {1'b0, acc[DATA_W-1:1]};
                writes_acc = 1'b1;
            end
            default: begin
                result     = acc;
                writes_acc = 1'b0;
            end
        endcase
    end

    assign acc_zero = (acc == '0);

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int ADDR_W = DATA_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              halted
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
    } core_st_t;

    core_st_t st_d, st_q;

    phase_t            phase;
    opcode_t           op;
    logic [ADDR_W-1:0] opnd_addr;
    logic [DATA_W-1:0] alu_res;
    logic              alu_wr;
    logic              acc_zero;
    logic              halt_req;

    assign op        = opcode_t'(st_q.ir[DATA_W-1 -: OP_W]);
    assign opnd_addr = st_q.ir[ADDR_W-1:0];
    assign halt_req  = (phase == PH_EXEC) && (op == OP_HLT);

    acc_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .phase    (phase),
        .halted   (halted)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op         (op),
        .acc        (st_q.acc),
        .operand    (mem_rdata),
        .result     (alu_res),
        .writes_acc (alu_wr),
        .acc_zero   (acc_zero)
    );

    always_comb begin
        st_d      = st_q;
        mem_addr  = st_q.pc;
        mem_we    = 1'b0;
        mem_wdata = st_q.acc;
        if (!halted) begin
            unique case (phase)
                PH_FETCH: begin
                    mem_addr = st_q.pc;
                end
                PH_DECODE: begin
                    st_d.ir = mem_rdata;
                    st_d.pc = st_q.pc + 1'b1;
                end
                PH_PREP: begin
                    mem_addr = opnd_addr;
                end
                PH_EXEC: begin
                    mem_addr = opnd_addr;
                    if (alu_wr) begin
                        st_d.acc = alu_res;
                    end
                    unique case (op)
                        OP_MOVS: mem_we = 1'b1;
                        OP_JMP:  st_d.pc = opnd_addr;
                        OP_JZ: begin
                            if (acc_zero) begin
                                st_d.pc = opnd_addr;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_core_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input phase_t            phase,
    input logic              halted,
    input logic              mem_we,
    input logic [ADDR_W-1:0] pc
);

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> (phase == PH_DECODE)); // R2
    AST_DECODE_TO_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |=> (phase == PH_PREP)); // R2
    AST_PREP_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PREP) |=> (phase == PH_EXEC)); // R2
    AST_EXEC_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && !halted) |=> (phase == PH_FETCH || halted)); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |=> (pc == $past(pc) + 1'b1)); // R3
    AST_WE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase == PH_EXEC)); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R11
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we); // R11
    AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(pc)); // R11

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .halted (halted),
    .mem_we (mem_we),
    .pc     (st_q.pc)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;

    localparam int DW = 16;
    localparam int AW = 12;
    localparam int MEMN = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;
    logic          halted;

    logic [DW-1:0] mem [MEMN];
    logic [DW-1:0] img [MEMN];
    logic          load_req = 1'b0;
    logic          we_seen;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    acc_core u_acc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (load_req) begin
            mem <= img;
        end else begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
        return {op, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < MEMN; i++) img[i] = '0;
    endtask

    task automatic boot();
        rst_n = 1'b0;
        load_req = 1'b1;
        @(posedge clk);
        #1 load_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic run_to_halt(input string req);
        int n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, halted}, 32'd1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_img();
        img[0] = ins(4'd0, 12'd0);
        rst_n = 1'b0;
        load_req = 1'b1;
        @(posedge clk);
        #1 load_req = 1'b0;
        @(negedge clk);
        chk("R1 addr in reset", 32'(mem_addr), 32'd0);
        chk("R1 we in reset", 32'(mem_we), 32'd0);
        chk("R1 halted in reset", 32'(halted), 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1 first fetch addr", 32'(mem_addr), 32'd0);
        chk("R1 halted after release", 32'(halted), 32'd0);
    endtask

    task automatic t_phases();
        logic [AW-1:0] trace [10];
        logic          ht [10];
        clear_img();
        img[0] = ins(4'd1, 12'h020);
        img[1] = ins(4'd0, 12'h000);
        boot();
        for (int k = 0; k < 10; k++) begin
            trace[k] = mem_addr;
            ht[k] = halted;
            @(negedge clk);
        end
        chk("R3 fetch0 addr", 32'(trace[0]), 32'h000);
        chk("R4 prep addr", 32'(trace[2]), 32'h020);
        chk("R4 exec addr", 32'(trace[3]), 32'h020);
        chk("R2 next fetch after 4 cycles", 32'(trace[4]), 32'h001);
        chk("R11 not halted during exec", 32'(ht[7]), 32'd0);
        chk("R11 halted after exec", 32'(ht[8]), 32'd1);
    endtask

    task automatic t_add_movl();
        clear_img();
        img[0] = ins(4'd2, 12'h040);
        img[1] = ins(4'd1, 12'h041);
        img[2] = ins(4'd3, 12'h050);
        img[3] = ins(4'd2, 12'h042);
        img[4] = ins(4'd1, 12'h043);
        img[5] = ins(4'd3, 12'h051);
        img[6] = ins(4'd2, 12'h044);
        img[7] = ins(4'd3, 12'h052);
        img[8] = ins(4'd0, 12'h000);
        img[8'h40] = 16'hFFF0;
        img[8'h41] = 16'h0025;
        img[8'h42] = 16'h1234;
        img[8'h43] = 16'h0101;
        img[8'h44] = 16'hA5C3;
        boot();
        run_to_halt("R11 add program halts");
        chk("R5 add wraps", 32'(mem[8'h50]), 32'h0015);
        chk("R5 add no carry", 32'(mem[8'h51]), 32'h1335);
        chk("R6 movl load", 32'(mem[8'h52]), 32'hA5C3);
        chk("R7 source word untouched", 32'(mem[8'h40]), 32'hFFF0);
    endtask

    task automatic t_shr();
        clear_img();
        img[0] = ins(4'd2, 12'h040);
        img[1] = ins(4'd4, 12'h000);
        img[2] = ins(4'd3, 12'h050);
        img[3] = ins(4'd4, 12'h000);
        img[4] = ins(4'd3, 12'h051);
        img[5] = ins(4'd2, 12'h041);
        img[6] = ins(4'd4, 12'h000);
        img[7] = ins(4'd3, 12'h052);
        img[8] = ins(4'd0, 12'h000);
        img[8'h40] = 16'h8001;
        img[8'h41] = 16'hFFFF;
        boot();
        run_to_halt("R11 shr program halts");
        chk("R8 shr top bit zero", 32'(mem[8'h50]), 32'h4000);
        chk("R8 shr twice", 32'(mem[8'h51]), 32'h2000);
        chk("R8 shr all ones", 32'(mem[8'h52]), 32'h7FFF);
    endtask

    task automatic t_jmp();
        clear_img();
        img[0] = ins(4'd2, 12'h040);
        img[1] = ins(4'd5, 12'h004);
        img[2] = ins(4'd3, 12'h050);
        img[3] = ins(4'd0, 12'h000);
        img[4] = ins(4'd3, 12'h051);
        img[5] = ins(4'd0, 12'h000);
        img[8'h40] = 16'h0007;
        img[8'h50] = 16'hCAFE;
        boot();
        run_to_halt("R11 jmp program halts");
        chk("R9 skipped store", 32'(mem[8'h50]), 32'hCAFE);
        chk("R9 target store", 32'(mem[8'h51]), 32'h0007);
    endtask

    task automatic t_jz();
        clear_img();
        img[0] = ins(4'd2, 12'h040);
        img[1] = ins(4'd6, 12'h004);
        img[2] = ins(4'd3, 12'h050);
        img[3] = ins(4'd0, 12'h000);
        img[4] = ins(4'd2, 12'h041);
        img[5] = ins(4'd6, 12'h008);
        img[6] = ins(4'd3, 12'h051);
        img[7] = ins(4'd0, 12'h000);
        img[8] = ins(4'd3, 12'h052);
        img[9] = ins(4'd0, 12'h000);
        img[8'h40] = 16'h0000;
        img[8'h41] = 16'h0005;
        img[8'h50] = 16'hDEAD;
        img[8'h52] = 16'hBEEF;
        boot();
        run_to_halt("R11 jz program halts");
        chk("R10 taken skips store", 32'(mem[8'h50]), 32'hDEAD);
        chk("R10 not taken falls through", 32'(mem[8'h51]), 32'h0005);
        chk("R10 not taken target unused", 32'(mem[8'h52]), 32'hBEEF);
    endtask

    task automatic t_halt();
        logic [AW-1:0] a0;
        clear_img();
        img[0] = ins(4'd2, 12'h040);
        img[1] = ins(4'd0, 12'h000);
        img[2] = ins(4'd3, 12'h050);
        img[8'h40] = 16'h0009;
        img[8'h50] = 16'h1111;
        boot();
        run_to_halt("R11 halts");
        a0 = mem_addr;
        we_seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_we) we_seen = 1'b1;
            if (mem_addr !== a0) chk("R11 addr steady", 32'(mem_addr), 32'(a0));
        end
        chk("R11 no write when halted", 32'(we_seen), 32'd0);
        chk("R11 still halted", 32'(halted), 32'd1);
        chk("R11 later store not run", 32'(mem[8'h50]), 32'h1111);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_phases();
        t_add_movl();
        t_shr();
        t_jmp();
        t_jz();
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule